// File: doc/BRIEF.md
# Interlocked Read Handshake Link

This block holds both ends of a read transfer that crosses between two unrelated clock domains over a shared set of address/data lines. Three control lines carry the transfer: a read request, a data-ready line and a single acknowledge line. Both sides may drive the acknowledge line, and it behaves as a wired OR. The requester end takes a read command from local logic. It places the address on the shared lines and then collects the returned word. The responder end sits in front of a small read-only memory. It captures the address and later drives the stored word back onto the same lines.

No step of the transfer depends on elapsed time. Each side moves only after it has seen the other side's control line change, and it sees those lines through its own synchronizer chain. The shared lines are modelled as a resolved bus that reads zero when neither side enables its driver. The top level brings the control lines and the resolved bus out for observation.

Top module: `rdhs_link`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rd_valid` is 0, the three control lines are 0 and `link_bus` is 0.
- R2: While `link_req` is high, `link_bus` holds the accepted address, zero-extended, with the address in bits [ADDR_W-1:0]. The value stays unchanged for as long as the request stays high.
- R3: While `link_rdy` is high, `link_bus` holds the stored word for the captured address, and the value stays stable. The word at address a is the low DATA_W bits of (a * 40503) XOR 0x5A5AC3A5.
- R4: Each read produces exactly this sequence of control-line transitions: request rises, ack rises, request falls, ack falls, ready rises, ack rises, ready falls, ack falls.
- R5: At most one side drives the shared lines at any time. A side drives only while its own request or ready line is high, and the bus reads 0 otherwise.
- R6: Each read produces one `rd_valid` pulse, exactly one requester clock cycle long, with `rd_data` equal to the stored word for the requested address.
- R7: `cmd_ready` falls when a command is accepted. It returns only after the requester's final acknowledge is seen low. A `cmd_valid` given while `cmd_ready` is low starts no transfer.
- R8: Reads complete correctly whether the responder clock runs slower or faster than the requester clock.
- R9: Every address from 0 to 2**ADDR_W-1 returns its own word, including reads issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_clk | input | 1 | Requester-side clock |
| req_rst_n | input | 1 | Requester-side asynchronous reset, active low |
| rsp_clk | input | 1 | Responder-side clock |
| rsp_rst_n | input | 1 | Responder-side asynchronous reset, active low |
| cmd_valid | input | 1 | Read command strobe (requester domain) |
| cmd_addr | input | ADDR_W | Address of the read command |
| cmd_ready | output | 1 | Requester is idle and will take a command |
| rd_valid | output | 1 | One-cycle pulse marking a returned word |
| rd_data | output | DATA_W | Returned word |
| link_req | output | 1 | Read request control line |
| link_rdy | output | 1 | Data-ready control line |
| link_ack | output | 1 | Shared acknowledge line (OR of both drivers) |
| link_bus | output | DATA_W | Resolved shared address/data lines |

## Verification
The bench builds the block with DATA_W=16, ADDR_W=4 and SYNC_STAGES=2. With these values the whole 16-entry memory can be read, so both boundary addresses and every word in between are compared. The responder clock first runs slower than the requester clock and then faster, and its edges never line up with requester edges. This exercises both directions of synchronizer lag and the stale-acknowledge window at the start of back-to-back reads.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_REL, RQ_WAIT, RQ_ACK, RQ_DRAIN
  } rq_state_e;

  typedef enum logic [2:0] {
    RS_IDLE, RS_ACK, RS_FETCH, RS_DRIVE, RS_REL
  } rs_state_e;

  // Content of the read-only store, indexed by word address.
  function automatic logic [31:0] fill_word(input logic [31:0] idx);
    return (idx * 32'h0000_9E37) ^ 32'h5A5A_C3A5;
  endfunction

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gs] <= '0;
          else        chain[gs] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gs] <= '0;
          else        chain[gs] <= chain[gs-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/rdhs_requester.sv
module rdhs_requester
  import rdhs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              readreq_o,
  output logic              ack_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] bus_out_o,
  input  logic              ack_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] bus_i
);
  localparam int PAD_W = DATA_W - ADDR_W;

  rq_state_e         state, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic              ack_s, rdy_s;

  rdhs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ack_i, rdy_i}),
    .q     ({ack_s, rdy_s})
  );

  // Named protocol events
  logic ev_accept, ev_ack_seen, ev_ack_gone, ev_data, ev_rdy_gone, ev_drained;
  assign ev_accept   = (state == RQ_IDLE)  && cmd_valid;
  assign ev_ack_seen = (state == RQ_ADDR)  && ack_s;
  assign ev_ack_gone = (state == RQ_REL)   && !ack_s;
  assign ev_data     = (state == RQ_WAIT)  && rdy_s;
  assign ev_rdy_gone = (state == RQ_ACK)   && !rdy_s;
  assign ev_drained  = (state == RQ_DRAIN) && !ack_s;

  always_comb begin
    nxt = state;
    unique case (state)
      RQ_IDLE:  if (ev_accept)   nxt = RQ_ADDR;
      RQ_ADDR:  if (ev_ack_seen) nxt = RQ_REL;
      RQ_REL:   if (ev_ack_gone) nxt = RQ_WAIT;
      RQ_WAIT:  if (ev_data)     nxt = RQ_ACK;
      RQ_ACK:   if (ev_rdy_gone) nxt = RQ_DRAIN;
      RQ_DRAIN: if (ev_drained)  nxt = RQ_IDLE;
      default:                   nxt = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RQ_IDLE;
      addr_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      state    <= nxt;
      rd_valid <= ev_rdy_gone;
      if (ev_accept) addr_q  <= cmd_addr;
      if (ev_data)   rd_data <= bus_i;
    end
  end

  assign cmd_ready = (state == RQ_IDLE);
  assign readreq_o = (state == RQ_ADDR);
  assign bus_oe_o  = (state == RQ_ADDR);
  assign ack_o     = (state == RQ_ACK);
  generate
    if (PAD_W > 0) begin : g_pad
      assign bus_out_o = {{PAD_W{1'b0}}, addr_q};
    end else begin : g_nopad
      assign bus_out_o = addr_q;
    end
  endgenerate

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    readreq_o |=> (!readreq_o || $stable(bus_out_o))); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!ack_o && !readreq_o && !ack_s)); // R7
  AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(readreq_o) |-> $past(ack_s)); // R4
  AST_ACK_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(rdy_s)); // R4
endmodule

// File: rtl/rdhs_responder.sv
module rdhs_responder
  import rdhs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              rdy_o,
  output logic              ack_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] bus_out_o
);
  localparam int DEPTH = 1 << ADDR_W;

  rs_state_e         state, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              req_s, ack_s;
  logic [DATA_W-1:0] rom [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_rom
      assign rom[gi] = DATA_W'(fill_word(32'(gi)));
    end
  endgenerate

  rdhs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({req_i, ack_i}),
    .q     ({req_s, ack_s})
  );

  // Named protocol events
  logic ev_req_seen, ev_req_gone, ev_own_ack_gone, ev_ack_seen, ev_ack_gone;
  assign ev_req_seen     = (state == RS_IDLE)  && req_s;
  assign ev_req_gone     = (state == RS_ACK)   && !req_s;
  assign ev_own_ack_gone = (state == RS_FETCH) && !ack_s;
  assign ev_ack_seen     = (state == RS_DRIVE) && ack_s;
  assign ev_ack_gone     = (state == RS_REL)   && !ack_s;

  always_comb begin
    nxt = state;
    unique case (state)
      RS_IDLE:  if (ev_req_seen)     nxt = RS_ACK;
      RS_ACK:   if (ev_req_gone)     nxt = RS_FETCH;
      RS_FETCH: if (ev_own_ack_gone) nxt = RS_DRIVE;
      RS_DRIVE: if (ev_ack_seen)     nxt = RS_REL;
      RS_REL:   if (ev_ack_gone)     nxt = RS_IDLE;
      default:                       nxt = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      state <= nxt;
      if (ev_req_seen)     addr_q <= bus_i[ADDR_W-1:0];
      if (ev_own_ack_gone) data_q <= rom[addr_q];
    end
  end

  assign ack_o     = (state == RS_ACK);
  assign rdy_o     = (state == RS_DRIVE);
  assign bus_oe_o  = (state == RS_DRIVE);
  assign bus_out_o = data_q;

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> (!rdy_o || $stable(bus_out_o))); // R3
  AST_SILENT_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !bus_oe_o); // R5
  AST_READY_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> !ack_s); // R4
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s)); // R4
endmodule

// File: rtl/rdhs_link.sv
module rdhs_link #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              req_clk,
  input  logic              req_rst_n,
  input  logic              rsp_clk,
  input  logic              rsp_rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              link_req,
  output logic              link_rdy,
  output logic              link_ack,
  output logic [DATA_W-1:0] link_bus
);
  logic              rq_ack, rs_ack;
  logic              rq_oe, rs_oe;
  logic [DATA_W-1:0] rq_out, rs_out;

  rdhs_requester #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk       (req_clk),
    .rst_n     (req_rst_n),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_ready (cmd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .readreq_o (link_req),
    .ack_o     (rq_ack),
    .bus_oe_o  (rq_oe),
    .bus_out_o (rq_out),
    .ack_i     (link_ack),
    .rdy_i     (link_rdy),
    .bus_i     (link_bus)
  );

  rdhs_responder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rsp (
    .clk       (rsp_clk),
    .rst_n     (rsp_rst_n),
    .req_i     (link_req),
    .ack_i     (link_ack),
    .bus_i     (link_bus),
    .rdy_o     (link_rdy),
    .ack_o     (rs_ack),
    .bus_oe_o  (rs_oe),
    .bus_out_o (rs_out)
  );

  // Wired-OR acknowledge and resolved shared lines (zero when undriven)
  assign link_ack = rq_ack | rs_ack;
  assign link_bus = rq_oe ? rq_out : (rs_oe ? rs_out : '0);

  AST_ONE_DRIVER_RQ: assert property (@(posedge req_clk) disable iff (!req_rst_n)
    !(rq_oe && rs_oe)); // R5
  AST_ONE_DRIVER_RS: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
    !(rq_oe && rs_oe)); // R5
  AST_ACK_SINGLE_SOURCE: assert property (@(posedge req_clk) disable iff (!req_rst_n)
    !(rq_ack && rs_ack)); // R4
endmodule

// File: tb/tb_rdhs_link.sv
`timescale 1ns/1ps
module tb_rdhs_link;
  localparam int  DATA_W     = 16;
  localparam int  ADDR_W     = 4;
  localparam int  CLK_PERIOD = 10;
  localparam int  DEPTH      = 1 << ADDR_W;

  logic req_clk = 1'b0, rsp_clk = 1'b0;
  logic req_rst_n = 1'b0, rsp_rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic cmd_ready, rd_valid, link_req, link_rdy, link_ack;
  logic [DATA_W-1:0] rd_data, link_bus;

  real rsp_half = 6.5;
  int  checks = 0, errors = 0;
  int  issued = 0, returned = 0, step = 0;
  bit  mon_on = 1'b0, last_valid = 1'b0;
  bit  p_req = 1'b0, p_rdy = 1'b0, p_ack = 1'b0;
  logic [ADDR_W-1:0] cur_addr = '0;
  logic [DATA_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) req_clk = ~req_clk;
  initial begin
    #0.3;
    forever #(rsp_half) rsp_clk = ~rsp_clk;
  end

  rdhs_link #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut (
    .req_clk(req_clk), .req_rst_n(req_rst_n), .rsp_clk(rsp_clk), .rsp_rst_n(rsp_rst_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .link_req(link_req), .link_rdy(link_rdy),
    .link_ack(link_ack), .link_bus(link_bus)
  );

  function automatic logic [DATA_W-1:0] model_word(input int a);
    int unsigned v;
    v = (a * 40503) ^ 32'h5A5AC3A5;
    return v[DATA_W-1:0];
  endfunction

  // Expected line event codes: line*2+level, req=0, ack=1, rdy=2
  function automatic int exp_event(input int s);
    case (s)
      0: return 1;  1: return 3;  2: return 0;  3: return 2;
      4: return 5;  5: return 3;  6: return 4;  default: return 2;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Control-line ordering monitor
  always @(link_req or link_rdy or link_ack) begin
    if (mon_on) begin
      int code;
      code = -1;
      if (link_req !== p_req)      code = 0 + int'(link_req);
      else if (link_ack !== p_ack) code = 2 + int'(link_ack);
      else if (link_rdy !== p_rdy) code = 4 + int'(link_rdy);
      if (code >= 0) begin
        chk("R4 line transition", code, exp_event(step));
        step = (step + 1) % 8;
      end
      p_req = link_req; p_rdy = link_rdy; p_ack = link_ack;
    end
  end

  // Bus content monitor, sampled between both clocks' edges
  always @(negedge req_clk) begin
    if (mon_on) begin
      if (link_req)      chk("R2 bus carries address", link_bus, {{(DATA_W-ADDR_W){1'b0}}, cur_addr});
      else if (link_rdy) chk("R3 bus carries word", link_bus, model_word(int'(cur_addr)));
      else               chk("R5 bus idle reads zero", link_bus, 0);
    end
  end

  // Scoreboard monitor
  always @(negedge req_clk) begin
    if (mon_on) begin
      if (rd_valid && last_valid) chk("R6 valid longer than one cycle", 1, 0);
      if (rd_valid) begin
        returned++;
        if (exp_q.size() == 0) chk("R7 result without accepted command", 1, 0);
        else chk("R6 R9 returned word", rd_data, exp_q.pop_front());
      end
      last_valid = rd_valid;
    end
  end

  task automatic issue_read(input int a, input bit poke_busy);
    @(negedge req_clk);
    while (!cmd_ready) @(negedge req_clk);
    cmd_valid = 1'b1;
    cmd_addr  = ADDR_W'(a);
    cur_addr  = ADDR_W'(a);
    exp_q.push_back(model_word(a));
    issued++;
    @(negedge req_clk);
    chk("R7 ready drops on accept", cmd_ready, 0);
    if (poke_busy) begin
      cmd_addr = ADDR_W'(a ^ 12);
      repeat (6) @(negedge req_clk);
      chk("R7 still busy during poke", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge req_clk);
    while (!cmd_ready) @(negedge req_clk);
    repeat (8) @(negedge req_clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge req_clk);
    req_rst_n = 1'b1; rsp_rst_n = 1'b1;
    @(negedge req_clk);
    chk("R1 reset cmd_ready", cmd_ready, 1);
    chk("R1 reset rd_valid", rd_valid, 0);
    chk("R1 reset lines", {link_req, link_rdy, link_ack}, 0);
    chk("R1 reset bus", link_bus, 0);
    mon_on = 1'b1;
    // R9 boundary addresses, responder slower (R8)
    issue_read(0, 1'b0);
    issue_read(DEPTH-1, 1'b0);
    issue_read(5, 1'b0);
    drain();
    // R7 command while busy must be ignored
    issue_read(3, 1'b1);
    drain();
    chk("R7 one result per accepted command", returned, issued);
    // R9 full sweep back to back
    for (int a = 0; a < DEPTH; a++) issue_read(a, 1'b0);
    drain();
    // R8 responder faster than requester
    rsp_half = 3.5;
    repeat (10) @(negedge req_clk);
    for (int a = DEPTH-1; a >= 0; a--) issue_read(a, 1'b0);
    issue_read(10, 1'b1);
    drain();
    chk("R8 all reads returned", returned, issued);
    chk("R4 sequence complete", step, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge req_clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=complete");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule